// File: doc/BRIEF.md
# Dual-Memory Bus Break Comparator

This block is the condition matcher of one hardware debug break channel. Every clock it looks at one bus cycle and decides whether that cycle meets the programmed break condition. The cycle comes either from the main data bus or from one of two 16-bit auxiliary memory buses, called X and Y. Configuration inputs hold a break address and a break data value, each with a mask. Three condition fields give the access kind, the direction and the operand size. An auxiliary-mode enable and an X/Y select choose the bus being watched.

The address and data configuration words are 32 bits wide. In auxiliary mode each word is split in two. The upper half is the X comparison value and the lower half is the Y comparison value. The select input decides which half is used and which auxiliary bus is observed, so a condition never combines X and Y. The result is registered. A matching cycle gives a one-cycle pulse on `match` in the following clock. Sequencing between channels, execution counting and exception entry belong to other blocks.

Top module: `brk_match_unit`

## Requirements
- R1: While `rst` is high (synchronous, active high), `match` is 0 in the following cycle, whatever the bus inputs are.
- R2: With `cfg_aux_en`=0, a main-bus cycle (`mb_valid`=1) that passes the condition fields and has every unmasked address bit equal to `cfg_addr` gives `match`=1 one clock later. The data bits are also compared against `cfg_data` on data cycles (`mb_fetch`=0). On fetch cycles the data is ignored.
- R3: A mask bit of 1 makes the matching address or data bit don't-care. A mask bit of 0 requires that bit to be equal.
- R4: `cfg_kind`: 0 matches any access, 1 matches instruction fetch only, 2 matches data access only, 3 never matches.
- R5: `cfg_dir`: 0 never matches, 1 matches reads only, 2 matches writes only, 3 matches either direction (`*_write`=1 means write).
- R6: `cfg_size`: 0 matches any operand size. 1 (byte), 2 (word) and 3 (long) must equal `mb_size`, which uses the same codes. An auxiliary-bus cycle always counts as word size.
- R7: With `cfg_aux_en`=1 and `cfg_sel_y`=0, only the X bus is observed. Its address and data are compared with bits 31:16 of `cfg_addr`/`cfg_addr_mask` and `cfg_data`/`cfg_data_mask`. The main bus, the Y bus and the lower halves have no effect.
- R8: With `cfg_aux_en`=1 and `cfg_sel_y`=1, only the Y bus is observed. It is compared with bits 15:0 of the same four words. The main bus, the X bus and the upper halves have no effect.
- R9: In auxiliary mode a match needs `cfg_kind`=2, `cfg_dir` not 0, and `cfg_size` equal to 0 or 2. Any other setting never matches.
- R10: `match` is registered with one cycle of latency. Each sampled cycle sets `match` for exactly the next clock, back-to-back matches give back-to-back highs, and a cycle with no valid bus gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_aux_en | input | 1 | 1 = watch an auxiliary bus, 0 = watch the main bus |
| cfg_sel_y | input | 1 | Auxiliary select: 0 = X bus, 1 = Y bus |
| cfg_kind | input | 2 | Access-kind condition |
| cfg_dir | input | 2 | Direction condition |
| cfg_size | input | 2 | Operand-size condition |
| cfg_addr | input | ADDR_W | Break address (X in upper half, Y in lower half in auxiliary mode) |
| cfg_addr_mask | input | ADDR_W | Address don't-care mask |
| cfg_data | input | DATA_W | Break data (split like the address) |
| cfg_data_mask | input | DATA_W | Data don't-care mask |
| mb_valid | input | 1 | Main bus cycle present |
| mb_fetch | input | 1 | Main bus cycle is an instruction fetch |
| mb_write | input | 1 | Main bus cycle is a write |
| mb_size | input | 2 | Main bus operand size |
| mb_addr | input | ADDR_W | Main bus address |
| mb_data | input | DATA_W | Main bus data |
| xb_valid | input | 1 | X bus cycle present |
| xb_write | input | 1 | X bus cycle is a write |
| xb_addr | input | ADDR_W/2 | X bus address |
| xb_data | input | DATA_W/2 | X bus data |
| yb_valid | input | 1 | Y bus cycle present |
| yb_write | input | 1 | Y bus cycle is a write |
| yb_addr | input | ADDR_W/2 | Y bus address |
| yb_data | input | DATA_W/2 | Y bus data |
| match | output | 1 | Registered one-cycle break-condition pulse |

## Verification
The bench builds the block with the default ADDR_W = DATA_W = 32, so each auxiliary half is 16 bits. At this size the bench can sweep every combination of the three condition fields against every fetch, direction and size of a main-bus cycle, and every field combination in both auxiliary selections. It can also flip each of the 32 address and data bit positions one at a time, both masked and unmasked. This makes the half selection visible bit by bit: a flip in the unused half must never change `match`.

// File: rtl/brk_pkg.sv
package brk_pkg;

    typedef enum logic [1:0] {
        KIND_ANY   = 2'd0,
        KIND_FETCH = 2'd1,
        KIND_DATA  = 2'd2,
        KIND_OFF   = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        DIR_OFF = 2'd0,
        DIR_RD  = 2'd1,
        DIR_WR  = 2'd2,
        DIR_ANY = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        SZ_ANY  = 2'd0,
        SZ_BYTE = 2'd1,
        SZ_WORD = 2'd2,
        SZ_LONG = 2'd3
    } size_e;

    // Programmed bus-cycle condition
    typedef struct packed {
        kind_e kind;
        dir_e  dir;
        size_e size;
    } cond_t;

    // Attributes of the observed cycle after source selection
    typedef struct packed {
        logic  valid;
        logic  fetch;
        logic  write;
        size_e size;
    } cyc_t;

    function automatic logic kind_hit(kind_e k, logic fetch);
        case (k)
            KIND_ANY:   return 1'b1;
            KIND_FETCH: return fetch;
            KIND_DATA:  return !fetch;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic dir_hit(dir_e d, logic wr);
        case (d)
            DIR_RD:  return !wr;
            DIR_WR:  return wr;
            DIR_ANY: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic size_hit(size_e want, size_e seen);
        return (want == SZ_ANY) || (want == seen);
    endfunction

    // Only a data access of word or unspecified size may target X/Y memory
    function automatic logic aux_cond_legal(cond_t c);
        return (c.kind == KIND_DATA) && (c.dir != DIR_OFF) &&
               ((c.size == SZ_ANY) || (c.size == SZ_WORD));
    endfunction

endpackage

// File: rtl/brk_mask_cmp.sv
module brk_mask_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] ref_v,
    input  logic [W-1:0] obs_v,
    input  logic [W-1:0] mask,
    output logic         hit
);
    logic [W-1:0] bit_ok;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign bit_ok[i] = mask[i] | (ref_v[i] == obs_v[i]);
        end
    endgenerate

    assign hit = &bit_ok;
endmodule

// File: rtl/brk_src_sel.sv
module brk_src_sel
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                aux_en,
    input  logic                sel_y,
    input  cyc_t                mb_cyc,
    input  logic [ADDR_W-1:0]   mb_addr,
    input  logic [DATA_W-1:0]   mb_data,
    input  logic                xb_valid,
    input  logic                xb_write,
    input  logic [ADDR_W/2-1:0] xb_addr,
    input  logic [DATA_W/2-1:0] xb_data,
    input  logic                yb_valid,
    input  logic                yb_write,
    input  logic [ADDR_W/2-1:0] yb_addr,
    input  logic [DATA_W/2-1:0] yb_data,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [ADDR_W-1:0]   cfg_addr_mask,
    input  logic [DATA_W-1:0]   cfg_data,
    input  logic [DATA_W-1:0]   cfg_data_mask,
    output cyc_t                cyc,
    output logic [ADDR_W-1:0]   obs_addr,
    output logic [ADDR_W-1:0]   ref_addr,
    output logic [ADDR_W-1:0]   msk_addr,
    output logic [DATA_W-1:0]   obs_data,
    output logic [DATA_W-1:0]   ref_data,
    output logic [DATA_W-1:0]   msk_data,
    output logic                data_use
);
    localparam int AH = ADDR_W / 2;
    localparam int DH = DATA_W / 2;

    logic [AH-1:0] h_obs_a, h_ref_a, h_msk_a;
    logic [DH-1:0] h_obs_d, h_ref_d, h_msk_d;
    cyc_t          aux_cyc;

    // Pick the auxiliary lane: X uses upper halves, Y the lower halves
    always_comb begin
        aux_cyc.fetch = 1'b0;
        aux_cyc.size  = SZ_WORD;
        if (sel_y) begin
            aux_cyc.valid = yb_valid;
            aux_cyc.write = yb_write;
            h_obs_a = yb_addr;
            h_obs_d = yb_data;
            h_ref_a = cfg_addr[AH-1:0];
            h_msk_a = cfg_addr_mask[AH-1:0];
            h_ref_d = cfg_data[DH-1:0];
            h_msk_d = cfg_data_mask[DH-1:0];
        end else begin
            aux_cyc.valid = xb_valid;
            aux_cyc.write = xb_write;
            h_obs_a = xb_addr;
            h_obs_d = xb_data;
            h_ref_a = cfg_addr[ADDR_W-1:ADDR_W-AH];
            h_msk_a = cfg_addr_mask[ADDR_W-1:ADDR_W-AH];
            h_ref_d = cfg_data[DATA_W-1:DATA_W-DH];
            h_msk_d = cfg_data_mask[DATA_W-1:DATA_W-DH];
        end
    end

    // Route main bus or the widened auxiliary lane to the comparators
    always_comb begin
        if (aux_en) begin
            cyc      = aux_cyc;
            obs_addr = {{(ADDR_W-AH){1'b0}}, h_obs_a};
            ref_addr = {{(ADDR_W-AH){1'b0}}, h_ref_a};
            msk_addr = {{(ADDR_W-AH){1'b1}}, h_msk_a};
            obs_data = {{(DATA_W-DH){1'b0}}, h_obs_d};
            ref_data = {{(DATA_W-DH){1'b0}}, h_ref_d};
            msk_data = {{(DATA_W-DH){1'b1}}, h_msk_d};
            data_use = 1'b1;
        end else begin
            cyc      = mb_cyc;
            obs_addr = mb_addr;
            ref_addr = cfg_addr;
            msk_addr = cfg_addr_mask;
            obs_data = mb_data;
            ref_data = cfg_data;
            msk_data = cfg_data_mask;
            data_use = !mb_cyc.fetch;
        end
    end
endmodule

// File: rtl/brk_cycle_qual.sv
module brk_cycle_qual
    import brk_pkg::*;
(
    input  cond_t cond,
    input  cyc_t  cyc,
    input  logic  aux_en,
    output logic  qual
);
    logic fields_ok;
    logic mode_ok;

    assign fields_ok = kind_hit(cond.kind, cyc.fetch) &&
                       dir_hit(cond.dir, cyc.write) &&
                       size_hit(cond.size, cyc.size);
    assign mode_ok   = !aux_en || aux_cond_legal(cond);
    assign qual      = cyc.valid && fields_ok && mode_ok;
endmodule

// File: rtl/brk_match_unit.sv
module brk_match_unit
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_aux_en,
    input  logic                cfg_sel_y,
    input  logic [1:0]          cfg_kind,
    input  logic [1:0]          cfg_dir,
    input  logic [1:0]          cfg_size,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [ADDR_W-1:0]   cfg_addr_mask,
    input  logic [DATA_W-1:0]   cfg_data,
    input  logic [DATA_W-1:0]   cfg_data_mask,
    input  logic                mb_valid,
    input  logic                mb_fetch,
    input  logic                mb_write,
    input  logic [1:0]          mb_size,
    input  logic [ADDR_W-1:0]   mb_addr,
    input  logic [DATA_W-1:0]   mb_data,
    input  logic                xb_valid,
    input  logic                xb_write,
    input  logic [ADDR_W/2-1:0] xb_addr,
    input  logic [DATA_W/2-1:0] xb_data,
    input  logic                yb_valid,
    input  logic                yb_write,
    input  logic [ADDR_W/2-1:0] yb_addr,
    input  logic [DATA_W/2-1:0] yb_data,
    output logic                match
);
    cond_t             cond;
    cyc_t              mb_cyc;
    cyc_t              cyc;
    logic [ADDR_W-1:0] obs_addr, ref_addr, msk_addr;
    logic [DATA_W-1:0] obs_data, ref_data, msk_data;
    logic              data_use, qual, addr_hit, data_hit, hit_now;

    assign cond.kind    = kind_e'(cfg_kind);
    assign cond.dir     = dir_e'(cfg_dir);
    assign cond.size    = size_e'(cfg_size);
    assign mb_cyc.valid = mb_valid;
    assign mb_cyc.fetch = mb_fetch;
    assign mb_cyc.write = mb_write;
    assign mb_cyc.size  = size_e'(mb_size);

    brk_src_sel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_src (
        .aux_en(cfg_aux_en), .sel_y(cfg_sel_y), .mb_cyc(mb_cyc),
        .mb_addr(mb_addr), .mb_data(mb_data),
        .xb_valid(xb_valid), .xb_write(xb_write), .xb_addr(xb_addr), .xb_data(xb_data),
        .yb_valid(yb_valid), .yb_write(yb_write), .yb_addr(yb_addr), .yb_data(yb_data),
        .cfg_addr(cfg_addr), .cfg_addr_mask(cfg_addr_mask),
        .cfg_data(cfg_data), .cfg_data_mask(cfg_data_mask),
        .cyc(cyc), .obs_addr(obs_addr), .ref_addr(ref_addr), .msk_addr(msk_addr),
        .obs_data(obs_data), .ref_data(ref_data), .msk_data(msk_data),
        .data_use(data_use)
    );

    brk_cycle_qual u_qual (
        .cond(cond), .cyc(cyc), .aux_en(cfg_aux_en), .qual(qual)
    );

    brk_mask_cmp #(.W(ADDR_W)) u_addr_cmp (
        .ref_v(ref_addr), .obs_v(obs_addr), .mask(msk_addr), .hit(addr_hit)
    );

    brk_mask_cmp #(.W(DATA_W)) u_data_cmp (
        .ref_v(ref_data), .obs_v(obs_data), .mask(msk_data), .hit(data_hit)
    );

    assign hit_now = qual && addr_hit && (data_hit || !data_use);

    // Registered so the pulse lines up with a main-bus data-access break
    always_ff @(posedge clk) begin
        if (rst) match <= 1'b0;
        else     match <= hit_now;
    end
endmodule

// File: rtl/brk_match_chk.sv
module brk_match_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_aux_en,
    input logic       cfg_sel_y,
    input logic [1:0] cfg_kind,
    input logic [1:0] cfg_dir,
    input logic [1:0] cfg_size,
    input logic       mb_valid,
    input logic       xb_valid,
    input logic       yb_valid,
    input logic       match
);
    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        (!mb_valid && !xb_valid && !yb_valid) |=> !match); // R10

    AST_KIND_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        match |-> ($past(cfg_kind) != 2'd3)); // R4

    AST_DIR_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        match |-> ($past(cfg_dir) != 2'd0)); // R5

    AST_AUX_COND_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (match && $past(cfg_aux_en)) |->
            ($past(cfg_kind) == 2'd2 && $past(cfg_dir) != 2'd0 &&
             ($past(cfg_size) == 2'd0 || $past(cfg_size) == 2'd2))); // R9

    AST_MAIN_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        (match && !$past(cfg_aux_en)) |-> $past(mb_valid)); // R2

    AST_X_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        (match && $past(cfg_aux_en) && !$past(cfg_sel_y)) |-> $past(xb_valid)); // R7

    AST_Y_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        (match && $past(cfg_aux_en) && $past(cfg_sel_y)) |-> $past(yb_valid)); // R8
endmodule

bind brk_match_unit brk_match_chk u_chk (
    .clk(clk), .rst(rst), .cfg_aux_en(cfg_aux_en), .cfg_sel_y(cfg_sel_y),
    .cfg_kind(cfg_kind), .cfg_dir(cfg_dir), .cfg_size(cfg_size),
    .mb_valid(mb_valid), .xb_valid(xb_valid), .yb_valid(yb_valid),
    .match(match)
);

// File: tb/brk_match_unit_bench.sv
`timescale 1ns/1ps
module brk_match_unit_bench;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_aux_en, cfg_sel_y;
    logic [1:0]    cfg_kind, cfg_dir, cfg_size;
    logic [AW-1:0] cfg_addr, cfg_addr_mask;
    logic [DW-1:0] cfg_data, cfg_data_mask;
    logic          mb_valid, mb_fetch, mb_write;
    logic [1:0]    mb_size;
    logic [AW-1:0] mb_addr;
    logic [DW-1:0] mb_data;
    logic          xb_valid, xb_write, yb_valid, yb_write;
    logic [15:0]   xb_addr, xb_data, yb_addr, yb_data;
    logic          match;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    brk_match_unit #(.ADDR_W(AW), .DATA_W(DW)) u_brk_match_unit (
        .clk(clk), .rst(rst), .cfg_aux_en(cfg_aux_en), .cfg_sel_y(cfg_sel_y),
        .cfg_kind(cfg_kind), .cfg_dir(cfg_dir), .cfg_size(cfg_size),
        .cfg_addr(cfg_addr), .cfg_addr_mask(cfg_addr_mask),
        .cfg_data(cfg_data), .cfg_data_mask(cfg_data_mask),
        .mb_valid(mb_valid), .mb_fetch(mb_fetch), .mb_write(mb_write),
        .mb_size(mb_size), .mb_addr(mb_addr), .mb_data(mb_data),
        .xb_valid(xb_valid), .xb_write(xb_write), .xb_addr(xb_addr), .xb_data(xb_data),
        .yb_valid(yb_valid), .yb_write(yb_write), .yb_addr(yb_addr), .yb_data(yb_data),
        .match(match)
    );

    function automatic logic kind_ok(logic [1:0] k, logic fe);
        return (k == 2'd0) || (k == 2'd1 && fe) || (k == 2'd2 && !fe);
    endfunction
    function automatic logic dir_ok(logic [1:0] d, logic wr);
        return (d == 2'd3) || (d == 2'd1 && !wr) || (d == 2'd2 && wr);
    endfunction
    function automatic logic aux_legal();
        return cfg_kind == 2'd2 && cfg_dir != 2'd0 && (cfg_size == 2'd0 || cfg_size == 2'd2);
    endfunction

    // Expected result of the cycle currently on the inputs
    function automatic logic model();
        logic v, fe, wr, aok, dok;
        logic [1:0] sz;
        if (!cfg_aux_en) begin
            v = mb_valid; fe = mb_fetch; wr = mb_write; sz = mb_size;
            aok = ((mb_addr ^ cfg_addr) & ~cfg_addr_mask) == 0;
            dok = fe || (((mb_data ^ cfg_data) & ~cfg_data_mask) == 0);
        end else if (!cfg_sel_y) begin
            v = xb_valid; fe = 1'b0; wr = xb_write; sz = 2'd2;
            aok = ((xb_addr ^ cfg_addr[31:16]) & ~cfg_addr_mask[31:16]) == 0;
            dok = ((xb_data ^ cfg_data[31:16]) & ~cfg_data_mask[31:16]) == 0;
        end else begin
            v = yb_valid; fe = 1'b0; wr = yb_write; sz = 2'd2;
            aok = ((yb_addr ^ cfg_addr[15:0]) & ~cfg_addr_mask[15:0]) == 0;
            dok = ((yb_data ^ cfg_data[15:0]) & ~cfg_data_mask[15:0]) == 0;
        end
        return v && kind_ok(cfg_kind, fe) && dir_ok(cfg_dir, wr) &&
               (cfg_size == 2'd0 || cfg_size == sz) &&
               (!cfg_aux_en || aux_legal()) && aok && dok;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: match=%b expected %b (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Inputs are set at a falling edge; the result is read one full cycle later
    task automatic step(string tag);
        logic exp;
        exp = model();
        @(negedge clk);
        check(tag, match, exp);
    endtask

    task automatic base_cfg();
        cfg_aux_en = 0; cfg_sel_y = 0;
        cfg_kind = 2'd0; cfg_dir = 2'd3; cfg_size = 2'd0;
        cfg_addr = 32'hA5C3_1E96; cfg_addr_mask = '0;
        cfg_data = 32'h5A3C_E169; cfg_data_mask = '0;
        mb_valid = 1; mb_fetch = 0; mb_write = 0; mb_size = 2'd2;
        mb_addr = cfg_addr; mb_data = cfg_data;
        xb_valid = 0; xb_write = 0; xb_addr = cfg_addr[31:16]; xb_data = cfg_data[31:16];
        yb_valid = 0; yb_write = 0; yb_addr = cfg_addr[15:0];  yb_data = cfg_data[15:0];
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL R10: watchdog expired, actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        base_cfg();
        rst = 1;
        // R1: a matching cycle is present during reset
        repeat (2) @(negedge clk);
        check("R1", match, 1'b0);
        @(negedge clk);
        rst = 0;

        // R2/R4/R5/R6: every condition field against every main cycle type
        for (int k = 0; k < 4; k++)
          for (int d = 0; d < 4; d++)
            for (int s = 0; s < 4; s++)
              for (int f = 0; f < 2; f++)
                for (int w = 0; w < 2; w++)
                  for (int ms = 1; ms < 4; ms++) begin
                      string tag;
                      cfg_kind = 2'(k); cfg_dir = 2'(d); cfg_size = 2'(s);
                      mb_fetch = f[0]; mb_write = w[0]; mb_size = 2'(ms);
                      if (!kind_ok(cfg_kind, mb_fetch))     tag = "R4";
                      else if (!dir_ok(cfg_dir, mb_write))  tag = "R5";
                      else if (!(s == 0 || s == ms))        tag = "R6";
                      else                                  tag = "R2";
                      step(tag);
                  end

        // R2: data is ignored on an instruction fetch, compared on data access
        base_cfg();
        mb_data = ~cfg_data; mb_fetch = 1; step("R2");
        mb_fetch = 0; step("R2");
        mb_valid = 0; mb_data = cfg_data; step("R2");

        // R3: one bit at a time, masked and unmasked, address then data
        for (int b = 0; b < 32; b++)
            for (int m = 0; m < 2; m++) begin
                base_cfg();
                mb_addr = cfg_addr ^ (32'd1 << b);
                cfg_addr_mask = m ? (32'd1 << b) : 32'd0;
                step("R3");
                base_cfg();
                mb_data = cfg_data ^ (32'd1 << b);
                cfg_data_mask = m ? (32'd1 << b) : 32'd0;
                step("R3");
            end

        // R7/R8/R9: condition fields in both auxiliary selections; main bus mismatched
        for (int sy = 0; sy < 2; sy++)
          for (int k = 0; k < 4; k++)
            for (int d = 0; d < 4; d++)
              for (int s = 0; s < 4; s++)
                for (int w = 0; w < 2; w++) begin
                    base_cfg();
                    cfg_aux_en = 1; cfg_sel_y = sy[0];
                    cfg_kind = 2'(k); cfg_dir = 2'(d); cfg_size = 2'(s);
                    mb_addr = ~cfg_addr;
                    xb_valid = 1; yb_valid = 1; xb_write = w[0]; yb_write = w[0];
                    step(!aux_legal() ? "R9" : (sy != 0 ? "R8" : "R7"));
                end

        // R7/R8: only the selected bus's valid counts
        base_cfg(); cfg_aux_en = 1; cfg_kind = 2'd2;
        yb_valid = 1; step("R7");
        cfg_sel_y = 1; yb_valid = 0; xb_valid = 1; step("R8");

        // R7/R8: a flip in either half of the compare words only affects its own lane
        for (int sy = 0; sy < 2; sy++)
            for (int b = 0; b < 32; b++) begin
                base_cfg(); cfg_aux_en = 1; cfg_sel_y = sy[0]; cfg_kind = 2'd2;
                xb_valid = 1; yb_valid = 1;
                cfg_addr = cfg_addr ^ (32'd1 << b);
                step(sy != 0 ? "R8" : "R7");
                base_cfg(); cfg_aux_en = 1; cfg_sel_y = sy[0]; cfg_kind = 2'd2;
                xb_valid = 1; yb_valid = 1;
                cfg_data = cfg_data ^ (32'd1 << b);
                step(sy != 0 ? "R8" : "R7");
            end

        // R3: auxiliary lane masking uses the half of the mask that goes with the lane
        for (int sy = 0; sy < 2; sy++)
            for (int b = 0; b < 16; b++)
                for (int m = 0; m < 2; m++) begin
                    base_cfg(); cfg_aux_en = 1; cfg_sel_y = sy[0]; cfg_kind = 2'd2;
                    xb_valid = 1; yb_valid = 1;
                    xb_addr = xb_addr ^ (16'd1 << b);
                    yb_addr = yb_addr ^ (16'd1 << b);
                    cfg_addr_mask = m ? ((32'd1 << b) << (sy != 0 ? 0 : 16)) : 32'd0;
                    step("R3");
                end

        // R10: back-to-back matches, a gap, then a single match
        base_cfg();
        step("R10"); step("R10");
        mb_valid = 0; step("R10");
        mb_valid = 1; step("R10");
        mb_addr = ~cfg_addr; step("R10");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule